// File: doc/BRIEF.md
# Vertical Blanking Pulse Generator

The block produces the vertical blanking interval of a raster display controller. A blanking window opens on a start event and closes after a fixed number of horizontal lines, counted from the rising edges of a horizontal line tick. The normal start event is the rising edge of the vertical sync input. When vertical sync has gone missing, the start of the vertical ramp discharge opens the window instead, so the screen still gets a blanking interval on a free-running scan.

Two conditions override the counted window and hold the blanking output high for as long as they last: a video-off control and a supply-decay flag that suppresses the spot while the supply collapses. A 6-bit level code is passed straight through to the analog stage, which builds the DC level of the blanking pulse outside this block.

An internal monitor decides whether vertical sync is present. It sets on every sync edge and clears once twice the expected frame length in lines has passed without a sync edge.

Top module: `vblank_gen`

## Requirements
- R1: A rising edge on `vsync` sets `blank_out` high from the next clock edge on; holding `vsync` high does not start a second window.
- R2: While vertical sync is absent, a one-cycle `ramp_disch` strobe sets `blank_out` high from the next clock edge on.
- R3: The counted window lasts exactly `LINES` (default 22) rising edges of `line_tick`; `blank_out` falls at the clock edge that sees the `LINES`-th rising edge.
- R4: Vertical sync counts as present from the clock edge after a `vsync` rising edge until 2*`FRAME_LINES` (default 128) `line_tick` rising edges have passed with no further `vsync` edge; while present, `ramp_disch` has no effect on `blank_out`.
- R5: `blank_out` is high in every cycle in which `video_off` is high, and returns to the counted window state when it drops.
- R6: `blank_out` is high in every cycle in which `supply_decay` is high.
- R7: A start event during an active window restarts the count, so the window ends `LINES` line edges after the latest start.
- R8: `level_out` equals `level_code` in every cycle.
- R9: After reset `blank_out` is low, no window is active, and vertical sync counts as absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| line_tick | input | 1 | Horizontal line tick; each rising edge is one line |
| vsync | input | 1 | Vertical sync pulse, active high |
| ramp_disch | input | 1 | One-cycle strobe at the start of the vertical ramp discharge |
| video_off | input | 1 | Forces blanking while high |
| supply_decay | input | 1 | Supply-loss flag; forces blanking while high |
| level_code | input | 6 | DC level setting for the blanking pulse |
| blank_out | output | 1 | Vertical blanking pulse |
| level_out | output | 6 | Level setting passed to the analog stage |

## Verification
Every cycle, the assertions check that a start event opens a window with a cleared count, that the count stays below the line total and holds between line edges, that the window closes on the last line edge, that a sync edge marks sync present and that the gap counter stays inside its timeout, and that a discharge strobe does nothing while sync is present. Only the bench's scenarios show the whole window length seen at the output, the restart after a second sync, the exact line on which the sync monitor gives up and hands the start back to the discharge strobe, and the forced-blank and level pass-through behaviour at the ports.

// File: rtl/vbg_pkg.sv
package vbg_pkg;

  // Advance a line count; wraps to zero when the last line is reached.
  function automatic int unsigned f_line_next(input int unsigned cnt,
                                              input int unsigned total);
    return (cnt + 1 >= total) ? 0 : cnt + 1;
  endfunction

  // Number of line edges without sync after which sync is declared lost.
  function automatic int unsigned f_sync_timeout(input int unsigned frame_lines);
    return 2 * frame_lines;
  endfunction

  // Width of a counter that must hold values 0 .. limit.
  function automatic int unsigned f_cnt_w(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/vbg_edge.sv
module vbg_edge #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig_in,
  output logic [W-1:0] rise
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig_in;
  end

  for (genvar g = 0; g < W; g++) begin : g_rise
    assign rise[g] = sig_in[g] & ~prev_q[g];
  end

endmodule

// File: rtl/vbg_sync_mon.sv
module vbg_sync_mon
  import vbg_pkg::*;
#(
  parameter int unsigned FRAME_LINES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_rise,
  input  logic line_rise,
  output logic sync_present
);

  localparam int unsigned TIMEOUT = f_sync_timeout(FRAME_LINES);
  localparam int unsigned GW      = f_cnt_w(TIMEOUT);

  logic [GW-1:0] gap_q;
  logic          gap_last;

  assign gap_last = (32'(gap_q) == TIMEOUT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_present <= 1'b0;
      gap_q        <= '0;
    end else if (sync_rise) begin
      sync_present <= 1'b1;
      gap_q        <= '0;
    end else if (line_rise && sync_present) begin
      if (gap_last) begin
        sync_present <= 1'b0;
        gap_q        <= '0;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  // R4: a sync edge always marks sync present on the next cycle
  p_sync_seen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rise |=> sync_present);

  // R4: the gap count never reaches the timeout while sync is present
  p_gap_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_present |-> (32'(gap_q) < TIMEOUT));

endmodule

// File: rtl/vbg_line_cnt.sv
module vbg_line_cnt
  import vbg_pkg::*;
#(
  parameter int unsigned LINES = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic line_rise,
  output logic active
);

  localparam int unsigned CW = f_cnt_w(LINES);

  logic [CW-1:0] cnt_q;
  logic          last_line;

  assign last_line = (32'(cnt_q) == LINES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt_q  <= '0;
    end else if (active && line_rise) begin
      if (last_line) active <= 1'b0;
      cnt_q <= CW'(f_line_next(32'(cnt_q), LINES));
    end
  end

  // R1/R2/R7: any start opens (or reopens) the window with a clear count
  p_start_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && cnt_q == '0));

  // R3: count stays inside the line total
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (32'(cnt_q) < LINES));

  // R3: the last line edge closes the window
  p_window_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && line_rise && last_line && !start) |=> !active);

  // R3: without a line edge the count holds
  p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !line_rise && !start) |=> (active && $stable(cnt_q)));

endmodule

// File: rtl/vblank_gen.sv
module vblank_gen #(
  parameter int unsigned LINES       = 22,
  parameter int unsigned FRAME_LINES = 64,
  parameter int unsigned LVL_W       = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_tick,
  input  logic             vsync,
  input  logic             ramp_disch,
  input  logic             video_off,
  input  logic             supply_decay,
  input  logic [LVL_W-1:0] level_code,
  output logic             blank_out,
  output logic [LVL_W-1:0] level_out
);

  logic [1:0] rise;
  logic       line_rise;
  logic       sync_rise;
  logic       sync_present;
  logic       start_sync;
  logic       start_ramp;
  logic       start;
  logic       win_active;
  logic       forced;

  vbg_edge #(.W(2)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig_in({vsync, line_tick}),
    .rise  (rise)
  );

  assign line_rise = rise[0];
  assign sync_rise = rise[1];

  vbg_sync_mon #(.FRAME_LINES(FRAME_LINES)) u_sync_mon (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_rise   (sync_rise),
    .line_rise   (line_rise),
    .sync_present(sync_present)
  );

  assign start_sync = sync_rise;
  assign start_ramp = ramp_disch & ~sync_present;
  assign start      = start_sync | start_ramp;

  vbg_line_cnt #(.LINES(LINES)) u_line_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .line_rise(line_rise),
    .active   (win_active)
  );

  assign forced    = video_off | supply_decay;
  assign blank_out = win_active | forced;
  assign level_out = level_code;

  // R4: a discharge strobe while sync is present cannot open a window
  p_ramp_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_present && ramp_disch && !sync_rise && !win_active) |=> !win_active);

endmodule

// File: tb/test_vblank_gen.sv
module test_vblank_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_tick = 1'b0;
  logic       vsync = 1'b0;
  logic       ramp_disch = 1'b0;
  logic       video_off = 1'b0;
  logic       supply_decay = 1'b0;
  logic [5:0] level_code = '0;
  logic       blank_out;
  logic [5:0] level_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  vblank_gen i_vblank_gen (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .vsync(vsync),
    .ramp_disch(ramp_disch), .video_off(video_off), .supply_decay(supply_decay),
    .level_code(level_code), .blank_out(blank_out), .level_out(level_out)
  );

  // Vector: [10:9] start source (0 none, 1 vsync, 2 ramp), [8:1] line ticks, [0] expected blank
  localparam int NV = 14;
  localparam logic [10:0] VEC [NV] = '{
    {2'd2, 8'd0,   1'b1},  // R2: no sync yet, ramp opens window
    {2'd0, 8'd21,  1'b1},  // R3: still open after 21 lines
    {2'd0, 8'd1,   1'b0},  // R3: closes on line 22
    {2'd1, 8'd0,   1'b1},  // R1: vsync opens window
    {2'd0, 8'd10,  1'b1},
    {2'd1, 8'd0,   1'b1},  // R7: restart mid-window
    {2'd0, 8'd21,  1'b1},  // R7: 31 lines after first start, still open
    {2'd0, 8'd1,   1'b0},  // R7: closes 22 after restart
    {2'd2, 8'd0,   1'b0},  // R4: ramp ignored with sync present
    {2'd0, 8'd105, 1'b0},  // 127 lines since last sync
    {2'd2, 8'd0,   1'b0},  // R4: still present, still ignored
    {2'd0, 8'd1,   1'b0},  // R4: 128th line, sync lost
    {2'd2, 8'd0,   1'b1},  // R4: ramp fallback resumes
    {2'd0, 8'd22,  1'b0}   // R3: full window again
  };

  function automatic string tag_of(input logic [1:0] src);
    case (src)
      2'd1:    return "R1";
      2'd2:    return "R2/R4";
      default: return "R3/R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_vsync();
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); vsync = 1'b0;
  endtask

  task automatic pulse_ramp();
    @(negedge clk); ramp_disch = 1'b1;
    @(negedge clk); ramp_disch = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); line_tick = 1'b1;
      @(negedge clk); line_tick = 1'b0;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {line_tick, vsync, ramp_disch, video_off, supply_decay} = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9: reset state
    check("R9 blank after reset", {7'd0, blank_out}, 8'd0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [1:0] src;
      src = VEC[i][10:9];
      if (src == 2'd1) pulse_vsync();
      else if (src == 2'd2) pulse_ramp();
      ticks(int'(VEC[i][8:1]));
      cyc(1);
      check(tag_of(src), {7'd0, blank_out}, {7'd0, VEC[i][0]});
    end

    // R8: level pass-through under several codes
    level_code = 6'h00; cyc(1); check("R8 level", {2'b0, level_out}, 8'h00);
    level_code = 6'h3F; cyc(1); check("R8 level", {2'b0, level_out}, 8'h3F);
    level_code = 6'h2A; cyc(1); check("R8 level", {2'b0, level_out}, 8'h2A);

    // R5: video-off forces blank while idle, releases after
    video_off = 1'b1; cyc(1); check("R5 forced", {7'd0, blank_out}, 8'd1);
    ticks(30);               check("R5 held", {7'd0, blank_out}, 8'd1);
    video_off = 1'b0; cyc(1); check("R5 release", {7'd0, blank_out}, 8'd0);

    // R6: supply decay forces blank
    supply_decay = 1'b1; cyc(1); check("R6 forced", {7'd0, blank_out}, 8'd1);
    supply_decay = 1'b0; cyc(1); check("R6 release", {7'd0, blank_out}, 8'd0);

    // R1: vsync held high starts one window only
    @(negedge clk); vsync = 1'b1;
    cyc(1); check("R1 held sync opens", {7'd0, blank_out}, 8'd1);
    ticks(22); cyc(1);
    check("R1 held sync no retrigger", {7'd0, blank_out}, 8'd0);
    vsync = 1'b0;

    // R5: video-off during a window; window still ends on schedule
    pulse_vsync();
    ticks(5); video_off = 1'b1; ticks(17); video_off = 1'b0; cyc(1);
    check("R5 window closed under override", {7'd0, blank_out}, 8'd0);

    // R9: reset mid-window clears blank and sync presence
    pulse_vsync(); ticks(3);
    do_reset();
    check("R9 reset clears window", {7'd0, blank_out}, 8'd0);
    pulse_ramp(); cyc(1);
    check("R9 sync absent after reset", {7'd0, blank_out}, 8'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule